// File: doc/BRIEF.md
# Adaptive EPROM Programming Sequencer

This block programs a byte-wide one-time-programmable memory with an adaptive, verify-driven write loop. A host loads a first and a last address and pulses a start request. The sequencer then enables the programming supplies and holds the device reset line low. For each address it fetches the write byte from a byte source and places it on the device data bus. It then lowers chip-enable for a fixed one-millisecond programming pulse, releases the bus and reads the byte back with output-enable low. Failed compares are retried until the byte matches or the attempt limit runs out.

Once a byte matches, the sequencer presents it again and applies one longer reinforcing pulse. That pulse lasts three milliseconds for every attempt the byte needed. It then moves to the next address. If a byte never verifies, the whole run stops, the supplies drop, and the failing address is reported. All millisecond lengths are exact multiples of a clock-cycles-per-millisecond parameter.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset and while idle, chip-enable and output-enable are high, the sequencer does not drive the data bus, both supply enables are low, busy/done/fail are low and the device reset output is high.
- R2: Every pulse of the retry loop holds chip-enable low for exactly CYC_PER_MS clock cycles, with output-enable high and the write byte driven on the bus for the whole pulse.
- R3: Chip-enable and output-enable are never low in the same cycle. Output-enable only falls after the sequencer has left the bus undriven for at least one cycle. While output-enable is low only the device drives the bus.
- R4: A verify match ends the retry loop for that address. tries_o counts the pulses applied to the current address, and after a finished run it shows the count used by the last address.
- R5: If the byte at an address still mismatches after MAX_TRIES attempts (25 by default), the run ends with fail_o high and fail_addr_o holding that address. No reinforcing pulse is applied, later addresses get no pulses, and tries_o reads MAX_TRIES.
- R6: After a match, one extra pulse with the byte driven holds chip-enable low for exactly tries × OVER_MULT × CYC_PER_MS cycles (OVER_MULT = 3).
- R7: Addresses are processed from start_addr_i up to and including end_addr_i in ascending order. src_addr_o equals the address being programmed, and done_o goes high once the last address is finished.
- R8: Both supply enables are high and the device reset output is low from the cycle after start until the run ends, including every chip-enable pulse. They drop when done or fail is reported. done_o and fail_o stay high until the next accepted start.
- R9: A start request seen while busy is ignored. The run in progress continues with its original address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| start_addr_i | input | ADDR_W | First address to program |
| end_addr_i | input | ADDR_W | Last address to program (inclusive) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished with every byte verified |
| fail_o | output | 1 | Run aborted, device defective |
| fail_addr_o | output | ADDR_W | Address that failed to verify |
| tries_o | output | TRY_W | Attempts applied to the current address |
| src_addr_o | output | ADDR_W | Address presented to the byte source |
| src_data_i | input | DATA_W | Write byte for src_addr_o |
| dev_addr_o | output | ADDR_W | Device address pins |
| dev_data_io | inout | DATA_W | Device data bus |
| dev_ce_n_o | output | 1 | Device chip-enable, active low (program pulse) |
| dev_oe_n_o | output | 1 | Device output-enable, active low (verify) |
| dev_rst_n_o | output | 1 | Device reset line, held low during a run |
| vpp_en_o | output | 1 | Enable for the high programming supply |
| vdd_en_o | output | 1 | Enable for the raised core supply |

## Verification
The device model needs a set number of pulses per byte. The bench drives it with needs of exactly one, exactly the attempt limit, and one beyond the limit. An off-by-one in the retry cap would either abort a byte that should pass on its last attempt or apply a 26th pulse. Reinforcing pulses are measured per address against tries × 3 ms. A design that counted the extra pulse itself, or used a fixed length, gives wrong lengths. The bench watches for bus contention during verify, for overlap of chip-enable and output-enable, and for a run that continues past a failed byte or programs the last address twice or not at all. A start request injected mid-run must not restart the sequencer at a new range.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_POWER,
    S_SETUP,
    S_PULSE,
    S_RELEASE,
    S_VERIFY,
    S_RECOVER,
    S_OSETUP,
    S_OPULSE,
    S_ORELEASE
  } seq_state_e;

  // cycles of one retry-loop pulse
  function automatic int unsigned pulse_cycles(int unsigned cpm);
    return cpm;
  endfunction

  // cycles of the reinforcing pulse after a byte verified
  function automatic int unsigned over_cycles(int unsigned tries, int unsigned mult,
                                              int unsigned cpm);
    return tries * mult * cpm;
  endfunction

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/prog_fsm.sv
module prog_fsm
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_MS = 250000,
  parameter int MAX_TRIES  = 25,
  parameter int OVER_MULT  = 3,
  parameter int SUPPLY_CYC = 4,
  parameter int VFY_CYC    = 2,
  parameter int CNT_W      = 8,
  parameter int TRY_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              bus_drv_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [TRY_W-1:0]  tries_o,
  output logic              over_pulse_o
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, end_q, fail_addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [TRY_W-1:0]  tries_q;
  logic              match_q, done_q, fail_q;

  wire last_try  = (tries_q == TRY_W'(MAX_TRIES));
  wire last_addr = (addr_q == end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      end_q       <= '0;
      fail_addr_q <= '0;
      wdata_q     <= '0;
      tries_q     <= '0;
      match_q     <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          addr_q  <= start_addr_i;
          end_q   <= end_addr_i;
          tries_q <= '0;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          state_q <= S_POWER;
        end
        S_POWER:  if (tmr_zero_i) state_q <= S_SETUP;
        S_SETUP: begin
          wdata_q <= src_data_i;
          tries_q <= tries_q + 1'b1;
          state_q <= S_PULSE;
        end
        S_PULSE:   if (tmr_zero_i) state_q <= S_RELEASE;
        S_RELEASE: state_q <= S_VERIFY;
        S_VERIFY: if (tmr_zero_i) begin
          match_q <= (rd_data_i == wdata_q);
          state_q <= S_RECOVER;
        end
        S_RECOVER: begin
          if (match_q)        state_q <= S_OSETUP;
          else if (last_try) begin
            fail_q      <= 1'b1;
            fail_addr_q <= addr_q;
            state_q     <= S_IDLE;
          end else            state_q <= S_SETUP;
        end
        S_OSETUP: state_q <= S_OPULSE;
        S_OPULSE: if (tmr_zero_i) state_q <= S_ORELEASE;
        S_ORELEASE: begin
          if (last_addr) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            addr_q  <= addr_q + 1'b1;
            tries_q <= '0;
            state_q <= S_SETUP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // timer reloads on the cycle before each timed state
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      S_IDLE: begin
        tmr_load_o = start_i;
        tmr_val_o  = CNT_W'(SUPPLY_CYC - 1);
      end
      S_SETUP: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(pulse_cycles(CYC_PER_MS) - 1);
      end
      S_RELEASE: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(VFY_CYC - 1);
      end
      S_OSETUP: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(over_cycles(32'(tries_q), OVER_MULT, CYC_PER_MS) - 1);
      end
      default: ;
    endcase
  end

  assign bus_drv_o    = (state_q == S_SETUP) || (state_q == S_PULSE) ||
                        (state_q == S_OSETUP) || (state_q == S_OPULSE);
  assign wr_data_o    = (state_q == S_SETUP) ? src_data_i : wdata_q;
  assign ce_n_o       = !((state_q == S_PULSE) || (state_q == S_OPULSE));
  assign oe_n_o       = (state_q != S_VERIFY);
  assign over_pulse_o = (state_q == S_OPULSE);
  assign busy_o       = (state_q != S_IDLE);
  assign addr_o       = addr_q;
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_addr_o  = fail_addr_q;
  assign tries_o      = tries_q;

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_MS = 250000,
  parameter int MAX_TRIES  = 25,
  parameter int OVER_MULT  = 3,
  parameter int SUPPLY_CYC = 4,
  parameter int VFY_CYC    = 2,
  localparam int CNT_W     = $clog2(MAX_TRIES * OVER_MULT * CYC_PER_MS + SUPPLY_CYC + VFY_CYC + 1),
  localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [TRY_W-1:0]  tries_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  inout  wire  [DATA_W-1:0] dev_data_io,
  output logic              dev_ce_n_o,
  output logic              dev_oe_n_o,
  output logic              dev_rst_n_o,
  output logic              vpp_en_o,
  output logic              vdd_en_o
);

  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wr_data;
  logic              bus_drv, over_pulse;

  prog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  prog_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_PER_MS(CYC_PER_MS),
    .MAX_TRIES(MAX_TRIES), .OVER_MULT(OVER_MULT), .SUPPLY_CYC(SUPPLY_CYC),
    .VFY_CYC(VFY_CYC), .CNT_W(CNT_W), .TRY_W(TRY_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .end_addr_i   (end_addr_i),
    .src_data_i   (src_data_i),
    .rd_data_i    (dev_data_io),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .addr_o       (cur_addr),
    .wr_data_o    (wr_data),
    .bus_drv_o    (bus_drv),
    .ce_n_o       (dev_ce_n_o),
    .oe_n_o       (dev_oe_n_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .fail_addr_o  (fail_addr_o),
    .tries_o      (tries_o),
    .over_pulse_o (over_pulse)
  );

  assign dev_data_io = bus_drv ? wr_data : {DATA_W{1'bz}};
  assign src_addr_o  = cur_addr;
  assign dev_addr_o  = cur_addr;
  assign vpp_en_o    = busy_o;
  assign vdd_en_o    = busy_o;
  assign dev_rst_n_o = !busy_o;

endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int CYC_PER_MS = 4,
  parameter int MAX_TRIES  = 25,
  parameter int OVER_MULT  = 3,
  parameter int TRY_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             oe_n,
  input logic             bus_drv,
  input logic             busy,
  input logic             vpp_en,
  input logic             vdd_en,
  input logic             dev_rst_n,
  input logic             done,
  input logic             fail,
  input logic [TRY_W-1:0] tries,
  input logic             over_pulse
);

  int   lo_len;
  logic ce_q, over_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len <= 0;
      ce_q   <= 1'b1;
      over_q <= 1'b0;
    end else begin
      ce_q   <= ce_n;
      lo_len <= ce_n ? 0 : lo_len + 1;
      if (!ce_n) over_q <= over_pulse;
    end
  end

  wire ce_rise = ce_n && !ce_q;

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !oe_n));

  a_r3_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> (!$past(bus_drv) && !bus_drv && $past(ce_n)));

  a_r2_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (bus_drv && oe_n));

  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && !over_q) |-> (lo_len == CYC_PER_MS));

  a_r6_over_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && over_q) |-> (lo_len == int'(tries) * OVER_MULT * CYC_PER_MS));

  a_r8_supply_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (vpp_en && vdd_en && !dev_rst_n));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_n && oe_n && !bus_drv && !vpp_en && dev_rst_n));

  a_r5_fail_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (int'(tries) == MAX_TRIES));

  a_r8_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .CYC_PER_MS(CYC_PER_MS), .MAX_TRIES(MAX_TRIES), .OVER_MULT(OVER_MULT), .TRY_W(TRY_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (dev_ce_n_o),
  .oe_n       (dev_oe_n_o),
  .bus_drv    (bus_drv),
  .busy       (busy_o),
  .vpp_en     (vpp_en_o),
  .vdd_en     (vdd_en_o),
  .dev_rst_n  (dev_rst_n_o),
  .done       (done_o),
  .fail       (fail_o),
  .tries      (tries_o),
  .over_pulse (over_pulse)
);

// File: tb/eprom_prog_seq_tb.sv
`timescale 1ns/1ps
module eprom_prog_seq_tb;

  localparam int AW = 6, DW = 8, CPM = 4, MAXT = 25, MULT = 3, TW = 5;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start;
  logic [AW-1:0] saddr, eaddr, fail_addr, src_addr, dev_addr;
  logic [DW-1:0] src_data;
  logic [TW-1:0] tries;
  logic busy, done, fail, ce_n, oe_n, dev_rst_n, vpp_en, vdd_en;
  wire  [DW-1:0] dev_data;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CYC_PER_MS(CPM), .MAX_TRIES(MAXT),
                   .OVER_MULT(MULT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(saddr), .end_addr_i(eaddr),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr), .tries_o(tries),
    .src_addr_o(src_addr), .src_data_i(src_data), .dev_addr_o(dev_addr),
    .dev_data_io(dev_data), .dev_ce_n_o(ce_n), .dev_oe_n_o(oe_n), .dev_rst_n_o(dev_rst_n),
    .vpp_en_o(vpp_en), .vdd_en_o(vdd_en));

  function automatic logic [DW-1:0] src_byte(logic [AW-1:0] a);
    return (8'(a) * 8'd29 + 8'd3) & 8'h7F;  // never the erased value 8'hFF
  endfunction

  // device model: byte a programs on its need[a]-th pulse, reads 8'hFF before
  logic [DW-1:0] mem [NA];
  int need [NA];
  int npulse [NA];
  int olen [NA];
  int lo_len = 0, prot_err = 0, len_err = 0;
  logic [DW-1:0] lat, prev_bus;
  logic prev_oe = 1'b1;

  assign src_data = src_byte(src_addr);
  assign dev_data = (!oe_n && ce_n) ? mem[dev_addr] : {DW{1'bz}};

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !oe_n) prot_err++;
    if (!ce_n && (!vpp_en || !vdd_en || dev_rst_n)) prot_err++;
    if (!oe_n && $isunknown(dev_data)) prot_err++;
    if (!oe_n && prev_oe && prev_bus !== {DW{1'bz}}) prot_err++;
    if (!ce_n) begin
      if ($isunknown(dev_data)) prot_err++;
      lo_len++;
      lat = dev_data;
    end else if (lo_len > 0) begin
      npulse[dev_addr]++;
      if (npulse[dev_addr] <= need[dev_addr] && lo_len != CPM) len_err++;
      if (npulse[dev_addr] == need[dev_addr]) mem[dev_addr] = lat;
      if (npulse[dev_addr] == need[dev_addr] + 1) olen[dev_addr] = lo_len;
      lo_len = 0;
    end
    prev_oe  = oe_n;
    prev_bus = dev_data;
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NA; i++) begin
      mem[i] = 8'hFF; npulse[i] = 0; olen[i] = 0;
    end
    prot_err = 0; len_err = 0;
  endtask

  task automatic run_case(input int sa, input int ea, input bit inject);
    int fail_at = -1;
    int bad_data = 0, bad_cnt = 0, bad_olen = 0, bad_after = 0, cyc = 0;
    for (int a = sa; a <= ea; a++) if (need[a] > MAXT) begin fail_at = a; break; end
    @(negedge clk);
    saddr = AW'(sa); eaddr = AW'(ea); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && vpp_en && vdd_en && !dev_rst_n, "R8", "supplies on after start",
        int'(vpp_en), 1);
    while (!(done || fail) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 15) begin
        saddr = '0; eaddr = AW'(NA - 1); start = 1'b1;  // R9: must be ignored
      end else start = 1'b0;
    end
    start = 1'b0;
    for (int a = sa; a <= ea; a++) begin
      if (fail_at >= 0 && a > fail_at) begin
        if (npulse[a] != 0 || mem[a] != 8'hFF) bad_after++;
      end else if (a == fail_at) begin
        if (npulse[a] != MAXT || mem[a] != 8'hFF) bad_cnt++;
      end else begin
        if (mem[a] != src_byte(AW'(a))) bad_data++;
        if (npulse[a] != need[a] + 1) bad_cnt++;
        if (olen[a] != need[a] * MULT * CPM) bad_olen++;
      end
    end
    chk(fail == (fail_at >= 0), "R5", "fail flag", int'(fail), int'(fail_at >= 0));
    chk(done == (fail_at < 0), "R7", "done flag", int'(done), int'(fail_at < 0));
    chk(bad_data == 0, "R7", "bytes programmed with source data", bad_data, 0);
    chk(bad_cnt == 0, "R4", "pulses per address", bad_cnt, 0);
    chk(bad_olen == 0, "R6", "reinforcing pulse length", bad_olen, 0);
    chk(len_err == 0, "R2", "retry pulse length", len_err, 0);
    chk(prot_err == 0, "R3", "bus/enable protocol", prot_err, 0);
    chk(!busy && !vpp_en && !vdd_en && dev_rst_n, "R8", "supplies off at end",
        int'(vpp_en), 0);
    if (fail_at >= 0) begin
      chk(bad_after == 0, "R5", "no pulses after failing address", bad_after, 0);
      chk(int'(fail_addr) == fail_at, "R5", "fail address", int'(fail_addr), fail_at);
      chk(int'(tries) == MAXT, "R5", "tries at abort", int'(tries), MAXT);
    end else
      chk(int'(tries) == need[ea], "R4", "tries of last address", int'(tries), need[ea]);
    if (inject)
      chk(bad_after == 0 && npulse[0] == 0 && npulse[NA-1] == 0, "R9",
          "mid-run start ignored", npulse[0] + npulse[NA-1], 0);
    repeat (3) @(negedge clk);
    chk(done == (fail_at < 0) && fail == (fail_at >= 0), "R8", "flags sticky",
        int'(done), int'(fail_at < 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; saddr = '0; eaddr = '0;
    for (int i = 0; i < NA; i++) need[i] = 1;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(ce_n && oe_n && !busy && !done && !fail && !vpp_en && !vdd_en && dev_rst_n,
        "R1", "idle outputs", int'({ce_n, oe_n, busy, vpp_en}), 4'b1100);
    chk(dev_data === {DW{1'bz}}, "R1", "bus released while idle", int'(dev_data === 'z), 1);

    // directed: one pulse, two, exactly the cap, three
    clear_model();
    need[10] = 1; need[11] = 2; need[12] = MAXT; need[13] = 3;
    run_case(10, 13, 1'b0);

    // directed abort in the middle of a range
    clear_model();
    need[20] = 2; need[21] = 1; need[22] = 99; need[23] = 1;
    run_case(20, 23, 1'b0);

    // single address and the top of the address space
    clear_model(); need[30] = 4;
    run_case(30, 30, 1'b0);
    clear_model(); need[61] = 1; need[62] = 5; need[63] = 2;
    run_case(61, 63, 1'b0);

    // start request during a run (R9)
    clear_model(); need[40] = 6; need[41] = 6;
    run_case(40, 41, 1'b1);

    // random ranges and needs
    for (int r = 0; r < 8; r++) begin
      int sa, ea;
      clear_model();
      sa = int'($urandom_range(1, 50));
      ea = sa + int'($urandom_range(0, 6));
      for (int a = sa; a <= ea; a++) begin
        need[a] = int'($urandom_range(1, 6));
        if ($urandom_range(0, 15) == 0) need[a] = MAXT + 1;
      end
      run_case(sa, ea, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule